// File: doc/BRIEF.md
# Front-End Slow-Control Register Bank

This block is the configuration store of a multi-channel front-end readout chip. An external controller reaches it over a four-wire serial port in SPI mode 0. Through that port it sets one discriminator threshold code for each group of channels, the pulse-stretcher width code, the test-pulse controls, and a per-channel readout enable mask. All of these settings are presented in parallel to the analog section.

The same port also reads back the 8-bit conversions of the applied threshold and width voltages. Software can therefore confirm what the analog circuits actually received, not only what was written. Every writable register loads a known value at reset, so the chip starts with usable thresholds before any configuration arrives.

The serial lines are sampled by the system clock through two-stage synchronizers. A control unit counts SCK edges and emits one-cycle strobes. A datapath unit holds the registers and the output shifter.

Top module: `slowCtrlSpi`

## Requirements
- R1: A frame is 16 bits sent MSB first while csN is low, with MOSI sampled on rising SCK. Bit 15 is the direction (1 = read, 0 = write), bits 14:8 are the 7-bit address and bits 7:0 are the data.
- R2: A write to address 0x00+g (g = 0..3) sets threshold group g, which appears on thrCode[8g+7:8g].
- R3: A write to address 0x04 sets widthCode.
- R4: Address 0x05 is the pulse control register. Bit 0 drives pulseEn and bit 1 drives pulseIntSel (1 = internal pulser); its other bits read as 0.
- R5: A write to address 0x08+k (k = 0..7) sets chanMask[8k+7:8k], where 1 enables readout of that channel.
- R6: After reset every threshold is 0x20, widthCode is 0x40, pulseEn and pulseIntSel are 0, and chanMask is all ones.
- R7: During the data phase of a read, the addressed byte is shifted out on MISO MSB first. Each bit is valid at rising SCK edges 9 to 16. A read changes no register.
- R8: Addresses 0x10+g return thrAdc[8g+7:8g], and address 0x14 returns widthAdc.
- R9: Writes to the ADC addresses and to unmapped addresses change no output. Unmapped addresses read as 0x00.
- R10: Raising csN before the 16th rising SCK edge discards the frame, and no register changes.
- R11: MISO is 0 while csN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rstN | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| csN | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| thrAdc | input | 32 | Threshold read-back conversions, one byte per group |
| widthAdc | input | 8 | Width read-back conversion |
| thrCode | output | 32 | Threshold codes, one byte per group |
| widthCode | output | 8 | Pulse-stretcher width code |
| pulseEn | output | 1 | Test pulse enable |
| pulseIntSel | output | 1 | Internal (1) or external (0) pulse source |
| chanMask | output | 64 | Per-channel readout enable |

## Verification
The bench goes after a frame cut short after ten bits. A design that commits on CS release or keeps a stale bit count would corrupt threshold 0 there, or would misalign the next frame.

It writes to read-only ADC addresses and to an unmapped address. A decoder that aliases on partial address bits would overwrite a live setting.

It reads back every register class with distinct byte patterns. Data shifted out one edge early or late shows up as a doubled or shifted MSB. A read frame whose data field is all ones must leave every register untouched.

// File: rtl/slowCtrlPkg.sv
package slowCtrlPkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  localparam int ADDR_THR     = 'h00;
  localparam int ADDR_WID     = 'h04;
  localparam int ADDR_CTL     = 'h05;
  localparam int ADDR_MASK    = 'h08;
  localparam int ADDR_THR_ADC = 'h10;
  localparam int ADDR_WID_ADC = 'h14;

  typedef struct packed {
    logic              wrEn;
    logic              rdLoad;
    logic              shiftOut;
    logic              clrOut;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } ctrlStrobe_t;
endpackage

// File: rtl/slowCtrlFsm.sv
module slowCtrlFsm
  import slowCtrlPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sck,
  input  logic        csN,
  input  logic        mosi,
  output ctrlStrobe_t stb
);
  logic [2:0]        sckSync;
  logic [1:0]        csSync;
  logic [1:0]        mosiSync;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-2:0] inShift;
  logic              hdrRead;
  logic [ADDR_W-1:0] hdrAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      csSync   <= '1;
      mosiSync <= '0;
    end else begin
      sckSync  <= {sckSync[1:0], sck};
      csSync   <= {csSync[0], csN};
      mosiSync <= {mosiSync[0], mosi};
    end
  end

  logic sckRise, sckFall, frameOn, bitIn;
  assign sckRise = sckSync[1] & ~sckSync[2];
  assign sckFall = ~sckSync[1] & sckSync[2];
  assign frameOn = ~csSync[1];
  assign bitIn   = mosiSync[1];

  logic hdrDone, dataDone;
  assign hdrDone  = frameOn && sckRise && (bitCnt == CNT_W'(ADDR_W));
  assign dataDone = frameOn && sckRise && (bitCnt == CNT_W'(FRAME_W - 1));

  logic [ADDR_W-1:0] liveAddr;
  assign liveAddr = {inShift[ADDR_W-2:0], bitIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      inShift <= '0;
      hdrRead <= 1'b0;
      hdrAddr <= '0;
    end else if (!frameOn) begin
      bitCnt <= '0;
    end else if (sckRise && bitCnt < CNT_W'(FRAME_W)) begin
      bitCnt  <= bitCnt + 1'b1;
      inShift <= {inShift[DATA_W-3:0], bitIn};
      if (hdrDone) begin
        hdrRead <= inShift[ADDR_W-1];
        hdrAddr <= liveAddr;
      end
    end
  end

  always_comb begin
    stb          = '0;
    stb.clrOut   = ~frameOn;
    stb.addr     = hdrDone ? liveAddr : hdrAddr;
    stb.wdata    = {inShift, bitIn};
    stb.rdLoad   = hdrDone && inShift[ADDR_W-1];
    stb.wrEn     = dataDone && !hdrRead;
    stb.shiftOut = frameOn && sckFall && (bitCnt >= CNT_W'(ADDR_W + 2));
  end
endmodule

// File: rtl/slowCtrlRegs.sv
module slowCtrlRegs
  import slowCtrlPkg::*;
#(
  parameter int                NUM_GROUPS   = 4,
  parameter int                NUM_CHANNELS = 64,
  parameter logic [DATA_W-1:0] THR_DEFAULT  = 8'h20,
  parameter logic [DATA_W-1:0] WID_DEFAULT  = 8'h40
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  stb,
  input  logic [NUM_GROUPS*DATA_W-1:0] thrAdc,
  input  logic [DATA_W-1:0]            widthAdc,
  output logic [NUM_GROUPS*DATA_W-1:0] thrCode,
  output logic [DATA_W-1:0]            widthCode,
  output logic                         pulseEn,
  output logic                         pulseIntSel,
  output logic [NUM_CHANNELS-1:0]      chanMask,
  output logic                         miso
);
  localparam int MASK_BYTES = NUM_CHANNELS / DATA_W;

  logic [DATA_W-1:0] outShift;
  logic [DATA_W-1:0] rdByte;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_thr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        thrCode[g*DATA_W +: DATA_W] <= THR_DEFAULT;
      else if (stb.wrEn && stb.addr == ADDR_W'(ADDR_THR + g))
        thrCode[g*DATA_W +: DATA_W] <= stb.wdata;
    end
  end

  for (genvar k = 0; k < MASK_BYTES; k++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        chanMask[k*DATA_W +: DATA_W] <= '1;
      else if (stb.wrEn && stb.addr == ADDR_W'(ADDR_MASK + k))
        chanMask[k*DATA_W +: DATA_W] <= stb.wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCode   <= WID_DEFAULT;
      pulseEn     <= 1'b0;
      pulseIntSel <= 1'b0;
    end else if (stb.wrEn) begin
      if (stb.addr == ADDR_W'(ADDR_WID)) widthCode <= stb.wdata;
      if (stb.addr == ADDR_W'(ADDR_CTL)) begin
        pulseEn     <= stb.wdata[0];
        pulseIntSel <= stb.wdata[1];
      end
    end
  end

  always_comb begin
    rdByte = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (stb.addr == ADDR_W'(ADDR_THR + g))     rdByte = thrCode[g*DATA_W +: DATA_W];
      if (stb.addr == ADDR_W'(ADDR_THR_ADC + g)) rdByte = thrAdc[g*DATA_W +: DATA_W];
    end
    for (int k = 0; k < MASK_BYTES; k++)
      if (stb.addr == ADDR_W'(ADDR_MASK + k)) rdByte = chanMask[k*DATA_W +: DATA_W];
    if (stb.addr == ADDR_W'(ADDR_WID))     rdByte = widthCode;
    if (stb.addr == ADDR_W'(ADDR_CTL))     rdByte = {{(DATA_W-2){1'b0}}, pulseIntSel, pulseEn};
    if (stb.addr == ADDR_W'(ADDR_WID_ADC)) rdByte = widthAdc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outShift <= '0;
    else if (stb.clrOut)   outShift <= '0;
    else if (stb.rdLoad)   outShift <= rdByte;
    else if (stb.shiftOut) outShift <= {outShift[DATA_W-2:0], 1'b0};
  end

  assign miso = outShift[DATA_W-1];
endmodule

// File: rtl/slowCtrlSpi.sv
module slowCtrlSpi
  import slowCtrlPkg::*;
#(
  parameter int                NUM_GROUPS   = 4,
  parameter int                NUM_CHANNELS = 64,
  parameter logic [DATA_W-1:0] THR_DEFAULT  = 8'h20,
  parameter logic [DATA_W-1:0] WID_DEFAULT  = 8'h40
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sck,
  input  logic                         csN,
  input  logic                         mosi,
  output logic                         miso,
  input  logic [NUM_GROUPS*DATA_W-1:0] thrAdc,
  input  logic [DATA_W-1:0]            widthAdc,
  output logic [NUM_GROUPS*DATA_W-1:0] thrCode,
  output logic [DATA_W-1:0]            widthCode,
  output logic                         pulseEn,
  output logic                         pulseIntSel,
  output logic [NUM_CHANNELS-1:0]      chanMask
);
  ctrlStrobe_t stb;

  slowCtrlFsm u_ctrl (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi), .stb(stb)
  );

  slowCtrlRegs #(
    .NUM_GROUPS(NUM_GROUPS), .NUM_CHANNELS(NUM_CHANNELS),
    .THR_DEFAULT(THR_DEFAULT), .WID_DEFAULT(WID_DEFAULT)
  ) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .thrAdc(thrAdc), .widthAdc(widthAdc),
    .thrCode(thrCode), .widthCode(widthCode), .pulseEn(pulseEn),
    .pulseIntSel(pulseIntSel), .chanMask(chanMask), .miso(miso)
  );
endmodule

// File: rtl/slowCtrlSpiChk.sv
module slowCtrlSpiChk
  import slowCtrlPkg::*;
#(
  parameter int                NUM_GROUPS   = 4,
  parameter int                NUM_CHANNELS = 64,
  parameter logic [DATA_W-1:0] THR_DEFAULT  = 8'h20,
  parameter logic [DATA_W-1:0] WID_DEFAULT  = 8'h40
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         csN,
  input logic                         miso,
  input ctrlStrobe_t                  stb,
  input logic [NUM_GROUPS*DATA_W-1:0] thrCode,
  input logic [DATA_W-1:0]            widthCode,
  input logic                         pulseEn,
  input logic                         pulseIntSel,
  input logic [NUM_CHANNELS-1:0]      chanMask
);
  logic [NUM_GROUPS*DATA_W+DATA_W+2+NUM_CHANNELS-1:0] cfgAll;
  assign cfgAll = {thrCode, widthCode, pulseEn, pulseIntSel, chanMask};

  p_defaults_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (thrCode == {NUM_GROUPS{THR_DEFAULT}}) && (widthCode == WID_DEFAULT)
                     && !pulseEn && !pulseIntSel && (&chanMask));

  p_change_needs_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$stable(cfgAll) |-> $past(stb.wrEn));

  p_adc_write_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn && stb.addr >= ADDR_W'(ADDR_THR_ADC) |=> $stable(cfgAll));

  p_strobe_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrEn, stb.rdLoad, stb.shiftOut}));

  p_idle_miso_r11: assert property (@(posedge clk) disable iff (!rstN)
    csN && $past(csN) && $past(csN, 2) && $past(csN, 3) |-> !miso);
endmodule

bind slowCtrlSpi slowCtrlSpiChk #(
  .NUM_GROUPS(NUM_GROUPS), .NUM_CHANNELS(NUM_CHANNELS),
  .THR_DEFAULT(THR_DEFAULT), .WID_DEFAULT(WID_DEFAULT)
) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .miso(miso), .stb(stb),
  .thrCode(thrCode), .widthCode(widthCode), .pulseEn(pulseEn),
  .pulseIntSel(pulseIntSel), .chanMask(chanMask)
);

// File: tb/tb_slowCtrlSpi.sv
module tb_slowCtrlSpi;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sck = 1'b0;
  logic        csN = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic [31:0] thrAdc = '0;
  logic [7:0]  widthAdc = '0;
  logic [31:0] thrCode;
  logic [7:0]  widthCode;
  logic        pulseEn, pulseIntSel;
  logic [63:0] chanMask;

  int nChk = 0;
  int nFail = 0;
  localparam int HALF = 8;

  always #4 clk = ~clk;

  slowCtrlSpi dut (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .thrAdc(thrAdc), .widthAdc(widthAdc), .thrCode(thrCode), .widthCode(widthCode),
    .pulseEn(pulseEn), .pulseIntSel(pulseIntSel), .chanMask(chanMask)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(bit rd, logic [6:0] addr, logic [7:0] wdata, int nbits,
                      output logic [7:0] rdata);
    logic [15:0] frame;
    frame = {rd, addr, wdata};
    rdata = '0;
    @(negedge clk);
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = frame[15-i];
      repeat (HALF) @(negedge clk);
      if (i >= 8) rdata = {rdata[6:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic wr(logic [6:0] addr, logic [7:0] d);
    logic [7:0] unused;
    xfer(1'b0, addr, d, 16, unused);
  endtask

  task automatic rdb(logic [6:0] addr, output logic [7:0] d);
    xfer(1'b1, addr, 8'hFF, 16, d);
  endtask

  task automatic t_reset;
    chk("R6 thrCode", thrCode, 64'h20202020);
    chk("R6 widthCode", widthCode, 64'h40);
    chk("R6 pulse ctl", {pulseIntSel, pulseEn}, 0);
    chk("R6 chanMask", chanMask, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R11 miso idle", miso, 0);
  endtask

  task automatic t_thresholds;
    logic [7:0] d;
    wr(7'h00, 8'hA1); wr(7'h01, 8'h5B); wr(7'h02, 8'h3C); wr(7'h03, 8'hE7);
    chk("R2 thrCode", thrCode, 64'hE73C5BA1);
    rdb(7'h01, d);
    chk("R7 R1 read thr1", d, 8'h5B);
    rdb(7'h03, d);
    chk("R7 read thr3", d, 8'hE7);
  endtask

  task automatic t_width_ctl;
    logic [7:0] d;
    wr(7'h04, 8'h96);
    chk("R3 widthCode", widthCode, 8'h96);
    rdb(7'h04, d);
    chk("R3 read width", d, 8'h96);
    wr(7'h05, 8'hFD);
    chk("R4 pulseEn", pulseEn, 1);
    chk("R4 pulseIntSel", pulseIntSel, 0);
    rdb(7'h05, d);
    chk("R4 read ctl", d, 8'h01);
    wr(7'h05, 8'h02);
    chk("R4 ctl bits", {pulseIntSel, pulseEn}, 2'b10);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    logic [63:0] exp;
    for (int k = 0; k < 8; k++) begin
      wr(7'(8 + k), 8'(8'h11 * (k + 1) ^ 8'h80));
      exp[k*8 +: 8] = 8'(8'h11 * (k + 1) ^ 8'h80);
    end
    chk("R5 chanMask", chanMask, exp);
    rdb(7'h0D, d);
    chk("R5 read mask byte 5", d, exp[47:40]);
  endtask

  task automatic t_adc;
    logic [7:0] d;
    thrAdc = 32'h8C_4E_13_F0;
    widthAdc = 8'h6A;
    for (int g = 0; g < 4; g++) begin
      rdb(7'(16 + g), d);
      chk("R8 thr adc", d, thrAdc[g*8 +: 8]);
    end
    rdb(7'h14, d);
    chk("R8 width adc", d, 8'h6A);
  endtask

  task automatic t_ignored;
    logic [7:0] d;
    logic [63:0] mSnap;
    logic [31:0] tSnap;
    logic [7:0] wSnap;
    mSnap = chanMask; tSnap = thrCode; wSnap = widthCode;
    wr(7'h12, 8'h00);
    wr(7'h14, 8'h00);
    wr(7'h30, 8'h00);
    chk("R9 thr unchanged", thrCode, tSnap);
    chk("R9 width unchanged", widthCode, wSnap);
    chk("R9 mask unchanged", chanMask, mSnap);
    rdb(7'h12, d);
    chk("R9 adc still reads input", d, 8'h4E);
    rdb(7'h30, d);
    chk("R9 unmapped reads 0", d, 8'h00);
    rdb(7'h00, d);
    chk("R7 read leaves regs", {thrCode, widthCode}, {tSnap, wSnap});
    chk("R11 miso idle after read", miso, 0);
  endtask

  task automatic t_abort;
    logic [7:0] d;
    xfer(1'b0, 7'h00, 8'h00, 10, d);
    chk("R10 abort 10 bits", thrCode[7:0], 8'hA1);
    xfer(1'b0, 7'h00, 8'h00, 15, d);
    chk("R10 abort 15 bits", thrCode[7:0], 8'hA1);
    wr(7'h00, 8'h42);
    chk("R10 next frame aligned", thrCode[7:0], 8'h42);
  endtask

  task automatic finish;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_thresholds();
    t_width_ctl();
    t_mask();
    t_adc();
    t_ignored();
    t_abort();
    finish();
  end
endmodule